// File: doc/BRIEF.md
# Burst Pseudo-Static RAM Device Engine

This block plays the memory side of a synchronous burst pseudo-static RAM bus. A controller starts a burst by holding chip enable low and pulsing address-valid low for one clock edge. The engine latches the start address and the direction on that edge. It raises WAIT while it counts the configured initial latency. It then moves one word per clock between the bus and an on-chip array. A burst address counter either wraps inside a fixed 4-, 8-, 16- or 32-word window or runs on continuously. In continuous mode it pauses with WAIT high each time it crosses into a new 128-word row.

Read and write data follow a push stream with no back-pressure. A word moves on every clock where chip enable is low, the engine is past its latency and WAIT is low. The controller cannot hold a beat off. It may only end the burst by raising chip enable. WAIT is therefore the only flow signal, and the controller must treat a low WAIT as "a beat happens at this edge". The engine serves as a simulation partner for a memory controller or as an emulator of the memory itself.

Top module: `psram_burst_engine`

## Requirements
- R1: With chip enable low and the engine idle, a rising edge where address-valid is low starts a burst at `addr`. The same edge samples `we_n` to set the direction: low means write, high means read. Address-valid is ignored once a burst is running.
- R2: WAIT is high from the cycle after the start edge for exactly L cycles and then drops. For writes, and for reads with `cfg_var` low, L = `cfg_lat` + REF_EXTRA. A computed L of zero behaves as one.
- R3: For a read with `cfg_var` high, L = `cfg_lat` when `refresh_busy` is low at the start edge, and `cfg_lat` + REF_EXTRA when it is high. Writes ignore `cfg_var` and `refresh_busy`.
- R4: `cfg_len` codes 0, 1, 2 and 3 select wrap windows of 4, 8, 16 and 32 words. The address low bits count up modulo the window, the upper bits stay fixed, and WAIT never rises again during the burst.
- R5: `cfg_len` code 4 (and codes 5 to 7) selects continuous mode, where the address increments by one per beat and wraps at the array end. Whenever the next address starts a 128-word row (low 7 bits zero), WAIT is high for ROW_STALL cycles before that word moves.
- R6: In a read burst, `rd_data` equals the array word at the current burst address on every beat while `oe_n` is low. At all other times it is zero.
- R7: In a write burst, `wr_data` is stored at the current burst address on each rising edge where WAIT is low.
- R8: Chip enable high drops WAIT at once and returns the engine to idle at the next edge. No array write happens on that edge or afterwards until a new burst starts.
- R9: During and after reset the engine is idle, with WAIT low and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Direction at the start edge: 0 write, 1 read |
| oe_n | input | 1 | Output enable for read data, active low |
| addr | input | AW | Burst start address |
| cfg_len | input | 3 | Burst length code: 0..3 wrap 4/8/16/32, 4..7 continuous |
| cfg_var | input | 1 | Variable read latency when high |
| cfg_lat | input | LAT_W | Latency count |
| refresh_busy | input | 1 | Refresh collision indication, sampled at the start edge |
| wr_data | input | DW | Write beat data |
| rd_data | output | DW | Read beat data, zero when not driven |
| wait_o | output | 1 | High while no beat can move |

## Verification
The bench builds the engine with an 8-bit address, so the array holds only two 128-word rows. With that size, one continuous burst crosses a row boundary and wraps from the array end back to zero. REF_EXTRA is 2 and ROW_STALL is 3. With different values, a refresh-extended latency and a row stall cannot be mistaken for each other or for a plain latency count. A 4-bit latency field lets `cfg_lat` of zero reach the minimum-latency case.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAT   = 2'd1,
    ST_DATA  = 2'd2,
    ST_STALL = 2'd3
  } eng_state_e;

  // words in one row; continuous bursts stall when crossing into a new one
  localparam int ROW_WORDS = 128;
  localparam int ROW_BITS  = $clog2(ROW_WORDS);
endpackage

// File: rtl/psram_burst_array.sv
module psram_burst_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/psram_burst_addr.sv
module psram_burst_addr
  import psram_burst_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic [2:0]    cfg_len,
  output logic [AW-1:0] baddr,
  output logic          row_cross
);
  logic [AW-1:0] incr, wrap_mask, nxt;
  logic          wrap_mode;

  always_comb begin
    incr = baddr + AW'(1);
    unique case (cfg_len)
      3'd0:    wrap_mask = AW'(3);
      3'd1:    wrap_mask = AW'(7);
      3'd2:    wrap_mask = AW'(15);
      3'd3:    wrap_mask = AW'(31);
      default: wrap_mask = '0;
    endcase
    wrap_mode = (cfg_len < 3'd4);
    nxt       = wrap_mode ? ((baddr & ~wrap_mask) | (incr & wrap_mask)) : incr;
    row_cross = step && !wrap_mode && (incr[ROW_BITS-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    baddr <= '0;
    else if (load) baddr <= load_addr;
    else if (step) baddr <= nxt;
  end

  // R4: a wrap-mode step keeps the bits above the window
  p_wrap_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap_mode && !load) |=>
      ((baddr & ~$past(wrap_mask)) == ($past(baddr) & ~$past(wrap_mask))));

  // R5: a flagged crossing lands on the first word of a row
  p_row_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_cross && !load) |=> (baddr[ROW_BITS-1:0] == '0));
endmodule

// File: rtl/psram_burst_timing.sv
module psram_burst_timing
  import psram_burst_pkg::*;
#(
  parameter int LAT_W     = 4,
  parameter int REF_EXTRA = 2,
  parameter int ROW_STALL = 3,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             we_n,
  input  logic             cfg_var,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             refresh_busy,
  input  logic             row_cross,
  output eng_state_e       state,
  output logic             is_wr,
  output logic             start
);
  localparam int MAX_LAT = (1 << LAT_W) - 1 + REF_EXTRA + 1;

  logic [CNT_W-1:0] cnt, lat_load;

  assign start = (state == ST_IDLE) && !ce_n && !adv_n;

  always_comb begin
    if (!we_n || !cfg_var || refresh_busy)
      lat_load = CNT_W'(cfg_lat) + CNT_W'(REF_EXTRA);
    else
      lat_load = CNT_W'(cfg_lat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
    end else if (ce_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (!adv_n) begin
          is_wr <= !we_n;
          cnt   <= lat_load;
          state <= ST_LAT;
        end
        ST_LAT: begin
          if (cnt <= CNT_W'(1)) state <= ST_DATA;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        ST_DATA: if (row_cross && ROW_STALL != 0) begin
          cnt   <= CNT_W'(ROW_STALL);
          state <= ST_STALL;
        end
        ST_STALL: begin
          if (cnt <= CNT_W'(1)) state <= ST_DATA;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker counters: cycles spent so far in the current latency / stall
  logic [CNT_W-1:0] lat_run, stall_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_run   <= '0;
      stall_run <= '0;
    end else begin
      lat_run   <= (state == ST_LAT)   ? lat_run + CNT_W'(1)   : '0;
      stall_run <= (state == ST_STALL) ? stall_run + CNT_W'(1) : '0;
    end
  end

  p_start_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_LAT));

  p_lat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAT) |-> (lat_run < CNT_W'(MAX_LAT)));

  p_stall_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STALL) |-> (stall_run < CNT_W'(ROW_STALL)));

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (state == ST_IDLE));
endmodule

// File: rtl/psram_burst_engine.sv
module psram_burst_engine
  import psram_burst_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int LAT_W     = 4,
  parameter int REF_EXTRA = 2,
  parameter int ROW_STALL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       cfg_len,
  input  logic             cfg_var,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             refresh_busy,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             wait_o
);
  localparam int MAX_CNT = (1 << LAT_W) + REF_EXTRA + ROW_STALL;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  eng_state_e    state;
  logic          is_wr, start, step, row_cross, mem_we;
  logic [AW-1:0] baddr;
  logic [DW-1:0] mem_q;

  psram_burst_timing #(
    .LAT_W(LAT_W), .REF_EXTRA(REF_EXTRA), .ROW_STALL(ROW_STALL), .CNT_W(CNT_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .cfg_var(cfg_var), .cfg_lat(cfg_lat), .refresh_busy(refresh_busy),
    .row_cross(row_cross), .state(state), .is_wr(is_wr), .start(start)
  );

  psram_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_addr(addr), .step(step),
    .cfg_len(cfg_len), .baddr(baddr), .row_cross(row_cross)
  );

  psram_burst_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(mem_we), .waddr(baddr), .wdata(wr_data),
    .raddr(baddr), .rdata(mem_q)
  );

  assign step    = !ce_n && (state == ST_DATA);
  assign mem_we  = step && is_wr;
  assign wait_o  = !ce_n && ((state == ST_LAT) || (state == ST_STALL));
  assign rd_data = (step && !is_wr && !oe_n) ? mem_q : '0;

  p_no_write_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !mem_we);

  p_write_no_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wait_o);

  p_rd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || wait_o) |-> (rd_data == '0));
endmodule

// File: tb/psram_burst_engine_bench.sv
`timescale 1ns/1ps
module psram_burst_engine_bench;
  localparam int AW = 8, DW = 16, LAT_W = 4, REF = 2, STALL = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [2:0] cfg_len = 3'd4;
  logic cfg_var = 1'b0, refresh_busy = 1'b0;
  logic [LAT_W-1:0] cfg_lat = 4'd3;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic wait_o;

  always #2.5 clk = ~clk;

  psram_burst_engine #(.AW(AW), .DW(DW), .LAT_W(LAT_W), .REF_EXTRA(REF), .ROW_STALL(STALL))
  u_psram_burst_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .cfg_len(cfg_len), .cfg_var(cfg_var), .cfg_lat(cfg_lat),
    .refresh_busy(refresh_busy), .wr_data(wr_data), .rd_data(rd_data), .wait_o(wait_o)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] model [256];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] a, input logic [2:0] len);
    logic [7:0] m;
    if (len >= 3'd4) return a + 8'd1;
    m = 8'((4 << len) - 1);
    return (a & ~m) | ((a + 8'd1) & m);
  endfunction

  function automatic logic [15:0] pat(input logic [7:0] a, input logic [15:0] salt);
    return {a, ~a} ^ salt;
  endfunction

  // one burst; abort_at >= 0 raises chip enable before that beat
  task automatic burst(input bit wr, input logic [7:0] a0, input logic [2:0] len,
                       input bit vr, input logic [3:0] lat, input bit refr, input int n,
                       input logic [15:0] salt, input bit oe_lo, input int abort_at);
    int lexp, gap, k, eg;
    logic [7:0] a;
    lexp = (wr || !vr || refr) ? int'(lat) + REF : int'(lat);
    if (lexp == 0) lexp = 1;
    cfg_len = len; cfg_var = vr; cfg_lat = lat; refresh_busy = refr;
    we_n = !wr; oe_n = !oe_lo; addr = a0; ce_n = 1'b0; adv_n = 1'b0;
    @(negedge clk);
    adv_n = 1'b1; refresh_busy = 1'b0; addr = ~a0;
    a = a0; gap = 0; k = 0;
    while (k < n) begin
      if (abort_at == k) begin
        ce_n = 1'b1; wr_data = 16'hDEAD;
        @(negedge clk);
        chk(wait_o == 1'b0, "R8 wait after abort", 32'(wait_o), 0);
        chk(rd_data == '0, "R8 data after abort", 32'(rd_data), 0);
        break;
      end
      if (wait_o) begin
        gap++;
        @(negedge clk);
      end else begin
        eg = (k == 0) ? lexp : ((len >= 3'd4 && a[6:0] == 7'd0) ? STALL : 0);
        chk(gap == eg, (k == 0) ? "R2/R3 initial latency" : "R4/R5 mid-burst wait",
            32'(gap), 32'(eg));
        if (wr) begin
          wr_data = pat(a, salt);
          model[a] = pat(a, salt);
        end else begin
          chk(rd_data == (oe_lo ? model[a] : 16'h0), "R6 read beat",
              32'(rd_data), 32'(oe_lo ? model[a] : 16'h0));
        end
        @(negedge clk);
        a = nxt(a, len); k++; gap = 0;
      end
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  // wr, addr, len, var, lat, refresh, beats, salt
  localparam logic [42:0] VEC [10] = '{
    {1'b1, 8'h00, 3'd4, 1'b0, 4'd3, 1'b0, 9'd256, 16'h0000},  // R7 R5 fill, cross + array wrap
    {1'b0, 8'h78, 3'd4, 1'b1, 4'd3, 1'b0, 9'd20,  16'h0000},  // R5 R3 row crossing
    {1'b0, 8'h45, 3'd0, 1'b1, 4'd3, 1'b1, 9'd8,   16'h0000},  // R4 R3 wrap 4, refresh
    {1'b0, 8'h3E, 3'd1, 1'b0, 4'd2, 1'b0, 9'd12,  16'h0000},  // R4 R2 wrap 8 fixed
    {1'b1, 8'h9B, 3'd2, 1'b0, 4'd1, 1'b0, 9'd20,  16'h1234},  // R7 R4 write wrap 16
    {1'b0, 8'h97, 3'd2, 1'b1, 4'd1, 1'b0, 9'd16,  16'h0000},  // R4 readback
    {1'b0, 8'hFD, 3'd3, 1'b1, 4'd0, 1'b1, 9'd40,  16'h0000},  // R4 wrap 32 no row stall
    {1'b0, 8'hF0, 3'd4, 1'b0, 4'd4, 1'b0, 9'd24,  16'h0000},  // R5 wrap past array end
    {1'b1, 8'h70, 3'd3, 1'b1, 4'd2, 1'b1, 9'd32,  16'hA5A5},  // R3 write ignores var
    {1'b0, 8'h60, 3'd4, 1'b1, 4'd2, 1'b0, 9'd40,  16'h0000}   // R1 read after write
  };

  initial begin
    #(WATCHDOG * 5);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ce_n = 1'b0; adv_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(wait_o == 1'b0, "R9 wait in reset", 32'(wait_o), 0);
    chk(rd_data == '0, "R9 data in reset", 32'(rd_data), 0);
    ce_n = 1'b1; adv_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(wait_o == 1'b0, "R9 wait after reset", 32'(wait_o), 0);
    chk(rd_data == '0, "R9 data after reset", 32'(rd_data), 0);

    for (int i = 0; i < 10; i++) begin
      burst(VEC[i][42], VEC[i][41:34], VEC[i][33:31], VEC[i][30], VEC[i][29:26],
            VEC[i][25], int'(VEC[i][24:16]), VEC[i][15:0], 1'b1, -1);
    end

    // R6: output enable high keeps read data at zero
    burst(1'b0, 8'h20, 3'd4, 1'b1, 4'd1, 1'b0, 6, 16'h0, 1'b0, -1);
    // R8: abort a write after three beats, then read back untouched words
    burst(1'b1, 8'h10, 3'd4, 1'b0, 4'd1, 1'b0, 10, 16'hFFFF, 1'b0, 3);
    burst(1'b0, 8'h10, 3'd4, 1'b1, 4'd1, 1'b0, 8, 16'h0, 1'b1, -1);
    // R8: abort while still in initial latency
    burst(1'b0, 8'h30, 3'd4, 1'b0, 4'd5, 1'b0, 4, 16'h0, 1'b1, 0);
    // R1: address-valid pulses mid-burst are ignored (read continues in order)
    fork
      burst(1'b0, 8'h50, 3'd1, 1'b1, 4'd1, 1'b0, 10, 16'h0, 1'b1, -1);
      begin
        repeat (4) @(negedge clk);
        adv_n = 1'b0;
        @(negedge clk);
        adv_n = 1'b1;
      end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule